// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps the rows of a dynamic memory array alive. It times out one row's share of the retention period and asks the command arbiter for a slot to reopen a row. In normal operation the row comes from an internal counter that walks the whole array. Software or a controller may instead name the row itself, one refresh at a time, with the internal counter left alone. A third style, a low-power self-refresh state, takes the arbiter out of the loop. The block then fires refreshes on its own timer, and that timer runs slower when the array is cold.

The per-row interval is the refresh period, given in clock cycles for the short period, divided by the row count. A period input doubles the interval for the long period. Every refresh holds the bank for one row cycle. An interval that expires while a refresh is still waiting or in progress is not lost: it is owed and served as soon as the bank frees up. An owed counter that runs out of room raises a sticky flag.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, ref_req, row_busy, self_active, sweep_pulse, owed_cnt and owed_ovf are 0, and ref_row shows row 0.
- R2: In counter mode (mode_sel = 0) a refresh request is raised every BASE = REFRESH_CYC_SHORT / NUM_ROWS cycles with period_long = 0, and every 2·BASE cycles with period_long = 1.
- R3: ref_req stays high until a cycle with ref_gnt high and falls in the next cycle.
- R4: A grant makes row_busy high for exactly T_RC cycles, starting the cycle after the grant. No request is raised while row_busy is high.
- R5: In counter mode ref_row carries the internal counter, which advances by one when each refresh completes, so consecutive refreshes visit rows 0, 1, 2 and so on.
- R6: After row NUM_ROWS-1 the counter returns to 0, and sweep_pulse is high for exactly the one cycle after that refresh's row cycle ends.
- R7: With mode_sel = 1 the timer raises nothing. A one-cycle ext_cmd pulse captures ext_row and raises a request carrying that row. These refreshes leave the internal counter unchanged.
- R8: An interval that expires while a request is pending or a row cycle runs raises owed_cnt by one, up to OWE_MAX. Once idle, each owed refresh raises a new request at once and lowers owed_cnt by one.
- R9: An interval that expires while owed_cnt equals OWE_MAX sets owed_ovf, which stays set until reset.
- R10: sr_enter takes effect only when no request is pending and no row cycle runs. In self-refresh, self_active is 1 and ref_req stays 0. Refreshes start internally every BASE cycles (with period_long = 0), each showing the counter row on ref_row and advancing it.
- R11: In self-refresh, ext_cmd, ext_row, ref_gnt, mode_sel and sr_enter have no effect on the state, the refresh spacing or the row sequence.
- R12: In self-refresh, temp_cold = 1 doubles the refresh interval. Outside self-refresh temp_cold has no effect.
- R13: sr_exit leaves self-refresh in the next cycle, and counter-mode requests resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | 0: internal counter rows, 1: externally named rows |
| ext_cmd | input | 1 | One-cycle command to refresh ext_row (mode_sel = 1) |
| ext_row | input | ROW_W | Row to refresh on ext_cmd |
| period_long | input | 1 | 1 selects the doubled refresh period |
| temp_cold | input | 1 | Low-temperature indication, stretches self-refresh interval |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_gnt | input | 1 | Arbiter grant for the pending refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_row | output | ROW_W | Row of the pending or running refresh |
| row_busy | output | 1 | Bank held for a row cycle |
| self_active | output | 1 | Self-refresh state |
| sweep_pulse | output | 1 | One-cycle pulse after a full array sweep |
| owed_cnt | output | OWE_W | Postponed refreshes still owed |
| owed_ovf | output | 1 | Sticky: a refresh was lost because owed_cnt was full |

## Verification
The bench withholds grants across four intervals. A scheduler that dropped expired intervals, wrapped the owed count, or failed to re-raise requests once idle would show the wrong owed_cnt, or a missing flag or request. It checks the row sequence across the wrap and through externally named refreshes. A counter that stepped on named rows, or pulsed the sweep at the wrong row or for two cycles, shows up there. In self-refresh it toggles every ignored input and measures the refresh spacing, warm and cold. Leaking commands through, or applying the cold stretch outside self-refresh, would shift that spacing or raise a request. It also tries entry while a request is pending, which must be refused.

// File: rtl/rs_pkg.sv
package rs_pkg;
    // mode_sel encoding
    localparam logic MODE_AUTO = 1'b0;
    localparam logic MODE_EXT  = 1'b1;

    // where the row of the pending refresh comes from
    typedef enum logic {
        SRC_COUNTER  = 1'b0,
        SRC_EXTERNAL = 1'b1
    } row_src_e;
endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
    parameter int BASE_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow_period,
    input  logic cold_slow,
    output logic tick
);
    localparam int CNT_W = $clog2(4 * BASE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [CNT_W-1:0] limit_m1;

    always_comb begin
        case ({slow_period, cold_slow})
            2'b00:   limit_m1 = CNT_W'(BASE_CYC - 1);
            2'b11:   limit_m1 = CNT_W'(4 * BASE_CYC - 1);
            default: limit_m1 = CNT_W'(2 * BASE_CYC - 1);
        endcase
        // >= so that a shortened limit wraps at once
        tick = run && (s_q.cnt >= limit_m1);
        s_d  = s_q;
        if (!run || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/rs_row_cycle.sv
module rs_row_cycle #(
    parameter int T_RC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int RC_W = $clog2(T_RC + 1);

    typedef struct packed {
        logic [RC_W-1:0] left;
    } rc_t;

    rc_t s_d, s_q;

    always_comb begin
        busy = (s_q.left != '0);
        done = (s_q.left == RC_W'(1));
        s_d  = s_q;
        if (start) begin
            s_d.left = RC_W'(T_RC);
        end else if (busy) begin
            s_d.left = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R4
    rc_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    // R4
    rc_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/rs_row_counter.sv
module rs_row_counter #(
    parameter int NUM_ROWS = 8,
    parameter int ROW_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row,
    output logic             sweep
);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             sweep;
    } rc_t;

    rc_t s_d, s_q;
    logic [ROW_W-1:0] nxt_row;

    generate
        if ((1 << ROW_W) == NUM_ROWS) begin : g_pow2
            assign nxt_row = s_q.row + 1'b1;
        end else begin : g_cmp
            assign nxt_row = (s_q.row == LAST) ? '0 : s_q.row + 1'b1;
        end
    endgenerate

    always_comb begin
        s_d       = s_q;
        s_d.sweep = advance && (s_q.row == LAST);
        if (advance) begin
            s_d.row = nxt_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign row   = s_q.row;
    assign sweep = s_q.sweep;

    // R6
    sweep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep |-> (row == '0));
    // R5
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && (row != LAST)) |=> (row == $past(row) + 1'b1));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rs_pkg::*;
#(
    parameter  int NUM_ROWS          = 8,
    parameter  int REFRESH_CYC_SHORT = 192,
    parameter  int T_RC              = 5,
    parameter  int OWE_MAX           = 3,
    localparam int ROW_W             = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int OWE_W             = $clog2(OWE_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             ext_cmd,
    input  logic [ROW_W-1:0] ext_row,
    input  logic             period_long,
    input  logic             temp_cold,
    input  logic             sr_enter,
    input  logic             sr_exit,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic [ROW_W-1:0] ref_row,
    output logic             row_busy,
    output logic             self_active,
    output logic             sweep_pulse,
    output logic [OWE_W-1:0] owed_cnt,
    output logic             owed_ovf
);
    localparam int BASE_CYC = REFRESH_CYC_SHORT / NUM_ROWS;

    typedef struct packed {
        logic             req;
        row_src_e         src;
        logic [ROW_W-1:0] ext_row;
        logic [OWE_W-1:0] owe;
        logic             ovf;
        logic             self_mode;
        logic             act_counter;
    } ctl_t;

    ctl_t s_d, s_q;

    logic             tick, busy, done;
    logic             grant, entering, auto_run, self_start, owe_more, start_rc;
    logic             tmr_run, tmr_cold;
    logic [ROW_W-1:0] cnt_row;
    logic             cnt_sweep;

    always_comb begin
        s_d        = s_q;
        grant      = s_q.req && ref_gnt && !s_q.self_mode;
        entering   = sr_enter && !s_q.self_mode && !s_q.req && !busy;
        auto_run   = !s_q.self_mode && (mode_sel == MODE_AUTO);
        self_start = 1'b0;
        owe_more   = 1'b0;

        if (grant) begin
            s_d.req = 1'b0;
        end

        if (s_q.self_mode) begin
            if (tick) begin
                if (busy) begin
                    owe_more = 1'b1;
                end else begin
                    self_start = 1'b1;
                end
            end else if (!busy && (s_q.owe != '0)) begin
                self_start = 1'b1;
                s_d.owe    = s_q.owe - 1'b1;
            end
            if (sr_exit) begin
                s_d.self_mode = 1'b0;
            end
        end else begin
            if (auto_run && tick) begin
                if (s_q.req || busy || entering) begin
                    owe_more = 1'b1;
                end else begin
                    s_d.req = 1'b1;
                    s_d.src = SRC_COUNTER;
                end
            end else if (auto_run && !s_q.req && !busy && !entering
                         && (s_q.owe != '0)) begin
                s_d.req = 1'b1;
                s_d.src = SRC_COUNTER;
                s_d.owe = s_q.owe - 1'b1;
            end
            if (!auto_run && ext_cmd && !s_q.req && !busy && !entering) begin
                s_d.req     = 1'b1;
                s_d.src     = SRC_EXTERNAL;
                s_d.ext_row = ext_row;
            end
            if (entering) begin
                s_d.self_mode = 1'b1;
            end
        end

        if (owe_more) begin
            if (s_q.owe == OWE_W'(OWE_MAX)) begin
                s_d.ovf = 1'b1;
            end else begin
                s_d.owe = s_q.owe + 1'b1;
            end
        end

        start_rc = grant || self_start;
        if (self_start) begin
            s_d.act_counter = 1'b1;
        end else if (grant) begin
            s_d.act_counter = (s_q.src == SRC_COUNTER);
        end

        tmr_run  = s_q.self_mode || auto_run;
        tmr_cold = s_q.self_mode && temp_cold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rs_interval_timer #(
        .BASE_CYC   (BASE_CYC)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (tmr_run),
        .slow_period(period_long),
        .cold_slow  (tmr_cold),
        .tick       (tick)
    );

    rs_row_cycle #(
        .T_RC (T_RC)
    ) u_rowcyc (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_rc),
        .busy (busy),
        .done (done)
    );

    rs_row_counter #(
        .NUM_ROWS(NUM_ROWS),
        .ROW_W   (ROW_W)
    ) u_rowcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (done && s_q.act_counter),
        .row     (cnt_row),
        .sweep   (cnt_sweep)
    );

    assign ref_req     = s_q.req;
    assign ref_row     = (s_q.src == SRC_EXTERNAL && !s_q.self_mode) ? s_q.ext_row : cnt_row;
    assign row_busy    = busy;
    assign self_active = s_q.self_mode;
    assign sweep_pulse = cnt_sweep;
    assign owed_cnt    = s_q.owe;
    assign owed_ovf    = s_q.ovf;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_gnt) |=> ref_req);
    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> !ref_req);
    // R4
    grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> row_busy);
    // R10
    self_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> !ref_req);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owed_ovf |=> owed_ovf);
    // R8
    owe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_cnt != $past(owed_cnt)) |->
        ((owed_cnt == $past(owed_cnt) + 1'b1) || (owed_cnt == $past(owed_cnt) - 1'b1)));
    // R11
    self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && !sr_exit) |=> self_active);
    // R13
    self_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (self_active && sr_exit) |=> !self_active);
endmodule

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
    localparam int NR   = 8;
    localparam int RCS  = 192;
    localparam int TRC  = 5;
    localparam int OMAX = 3;
    localparam int BASE = RCS / NR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel, ext_cmd, period_long, temp_cold, sr_enter, sr_exit, ref_gnt;
    logic [2:0] ext_row;
    logic       ref_req, row_busy, self_active, sweep_pulse, owed_ovf;
    logic [2:0] ref_row;
    logic [1:0] owed_cnt;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int exp_row = 0;

    dram_refresh_sched #(
        .NUM_ROWS(NR), .REFRESH_CYC_SHORT(RCS), .T_RC(TRC), .OWE_MAX(OMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ext_cmd(ext_cmd),
        .ext_row(ext_row), .period_long(period_long), .temp_cold(temp_cold),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_gnt(ref_gnt),
        .ref_req(ref_req), .ref_row(ref_row), .row_busy(row_busy),
        .self_active(self_active), .sweep_pulse(sweep_pulse),
        .owed_cnt(owed_cnt), .owed_ovf(owed_ovf)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_req(output int t);
        while (!ref_req) @(negedge clk);
        t = cyc;
    endtask

    task automatic grant_one(input string tag, input bit ctr, input int xrow);
        int n;
        int want;
        want = ctr ? exp_row : xrow;
        chk({tag, " row at grant"}, int'(ref_row), want);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R3 request drops after grant", int'(ref_req), 0);
        n = 0;
        while (row_busy) begin
            n++;
            if (ref_req) chk("R4 request during row cycle", 1, 0);
            @(negedge clk);
        end
        chk("R4 row cycle length", n, TRC);
        if (ctr) begin
            chk("R6 sweep pulse after refresh", int'(sweep_pulse), (exp_row == NR - 1) ? 1 : 0);
            exp_row = (exp_row + 1) % NR;
        end
        @(negedge clk);
        chk("R6 sweep pulse width", int'(sweep_pulse), 0);
    endtask

    task automatic wait_busy_rise(input string tag, output int t);
        while (row_busy) @(negedge clk);
        while (!row_busy) begin
            if (ref_req) chk({tag, " request in self-refresh"}, 1, 0);
            @(negedge clk);
        end
        t = cyc;
        chk({tag, " self-refresh row"}, int'(ref_row), exp_row);
        exp_row = (exp_row + 1) % NR;
    endtask

    task automatic test_reset();
        chk("R1 ref_req", int'(ref_req), 0);
        chk("R1 row_busy", int'(row_busy), 0);
        chk("R1 self_active", int'(self_active), 0);
        chk("R1 sweep_pulse", int'(sweep_pulse), 0);
        chk("R1 owed_cnt", int'(owed_cnt), 0);
        chk("R1 owed_ovf", int'(owed_ovf), 0);
        chk("R1 ref_row", int'(ref_row), 0);
    endtask

    task automatic test_auto();
        int t0, t1, t2;
        wait_req(t0);
        grant_one("R5", 1'b1, 0);
        wait_req(t1);
        chk("R2 short interval", t1 - t0, BASE);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 request held without grant", int'(ref_req), 1);
        end
        grant_one("R5", 1'b1, 0);
        wait_req(t2);
        chk("R2 interval with late grant", t2 - t1, BASE);
        grant_one("R5", 1'b1, 0);
    endtask

    task automatic test_long();
        int a, b, c;
        period_long = 1'b1;
        wait_req(a);
        grant_one("R5", 1'b1, 0);
        wait_req(b);
        grant_one("R5", 1'b1, 0);
        wait_req(c);
        chk("R2 long interval", c - b, 2 * BASE);
        grant_one("R5", 1'b1, 0);
        period_long = 1'b0;
    endtask

    task automatic test_wrap();
        int t;
        for (int i = 0; i < NR; i++) begin
            wait_req(t);
            grant_one("R6", 1'b1, 0);
        end
    endtask

    task automatic test_postpone();
        int t;
        wait_req(t);
        for (int k = 1; k <= OMAX; k++) begin
            while (cyc < t + BASE * k + 1) @(negedge clk);
            chk("R8 owed count grows", int'(owed_cnt), k);
            chk("R9 no overflow yet", int'(owed_ovf), 0);
        end
        while (cyc < t + BASE * (OMAX + 1) + 1) @(negedge clk);
        chk("R9 overflow raised", int'(owed_ovf), 1);
        chk("R8 owed count saturates", int'(owed_cnt), OMAX);
        grant_one("R8", 1'b1, 0);
        chk("R8 owed refresh re-requested", int'(ref_req), 1);
        chk("R8 owed count drops", int'(owed_cnt), OMAX - 1);
        while (owed_cnt != 0 || ref_req) begin
            if (ref_req) grant_one("R8", 1'b1, 0);
            else @(negedge clk);
        end
        chk("R9 overflow sticky", int'(owed_ovf), 1);
    endtask

    task automatic test_ext();
        int rises;
        mode_sel = 1'b1;
        @(negedge clk);
        if (ref_req) grant_one("R5", 1'b1, 0);
        ext_row = 3'd5;
        ext_cmd = 1'b1;
        @(negedge clk);
        ext_cmd = 1'b0;
        chk("R7 request on command", int'(ref_req), 1);
        grant_one("R7", 1'b0, 5);
        rises = 0;
        for (int i = 0; i < 3 * BASE; i++) begin
            if (ref_req) rises++;
            @(negedge clk);
        end
        chk("R7 timer silent in named-row mode", rises, 0);
        ext_row = 3'd2;
        ext_cmd = 1'b1;
        @(negedge clk);
        ext_cmd = 1'b0;
        grant_one("R7", 1'b0, 2);
        mode_sel = 1'b0;
        wait_req(rises);
        grant_one("R7 counter untouched", 1'b1, 0);
    endtask

    task automatic test_self();
        int t, r1, r2, r3, r4, r5, r6, b, c;
        wait_req(t);
        sr_enter = 1'b1;
        @(negedge clk);
        sr_enter = 1'b0;
        chk("R10 entry refused while pending", int'(self_active), 0);
        grant_one("R5", 1'b1, 0);
        sr_enter = 1'b1;
        @(negedge clk);
        sr_enter = 1'b0;
        chk("R10 entry when idle", int'(self_active), 1);
        chk("R10 no request after entry", int'(ref_req), 0);
        wait_busy_rise("R10", r1);
        wait_busy_rise("R10", r2);
        wait_busy_rise("R10", r3);
        chk("R10 self-refresh interval", r3 - r2, BASE);
        while (row_busy) @(negedge clk);
        mode_sel = 1'b1;
        ext_row  = 3'd3;
        ext_cmd  = 1'b1;
        ref_gnt  = 1'b1;
        sr_enter = 1'b1;
        @(negedge clk);
        ext_cmd  = 1'b0;
        ref_gnt  = 1'b0;
        sr_enter = 1'b0;
        chk("R11 still in self-refresh", int'(self_active), 1);
        chk("R11 no request", int'(ref_req), 0);
        wait_busy_rise("R11", r4);
        chk("R11 spacing unaffected", r4 - r3, BASE);
        mode_sel  = 1'b0;
        temp_cold = 1'b1;
        wait_busy_rise("R12", r5);
        wait_busy_rise("R12", r6);
        chk("R12 cold self-refresh interval", r6 - r5, 2 * BASE);
        sr_exit = 1'b1;
        @(negedge clk);
        sr_exit = 1'b0;
        chk("R13 self-refresh left", int'(self_active), 0);
        while (row_busy) @(negedge clk);
        wait_req(t);
        grant_one("R13", 1'b1, 0);
        wait_req(b);
        grant_one("R13", 1'b1, 0);
        wait_req(c);
        chk("R12 cold ignored outside self-refresh", c - b, BASE);
        grant_one("R13", 1'b1, 0);
        temp_cold = 1'b0;
    endtask

    initial begin
        mode_sel    = 1'b0;
        ext_cmd     = 1'b0;
        ext_row     = '0;
        period_long = 1'b0;
        temp_cold   = 1'b0;
        sr_enter    = 1'b0;
        sr_exit     = 1'b0;
        ref_gnt     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_auto();
        test_long();
        test_wrap();
        test_postpone();
        test_ext();
        test_self();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule